// File: doc/BRIEF.md
# External Interrupt Sense Converter

This block sits between a bank of external interrupt pins and a downstream interrupt controller that only accepts active-high level requests. Each line is set by two bits: one picks level or edge sensing, the other picks the active sense (high/rising or low/falling). Edge events are caught in a per-line latch and held until software clears them. Every line then passes through a mask and leaves the block as an active-high level request.

Software uses a small register port with a valid strobe and a write flag. Reads are combinational and answer in the same cycle. Every pin first passes through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the sample before it. Each line's latch is a two-state machine. In `LN_IDLE` nothing is pending. The `arm` transition enters `LN_HELD` on an edge event while the line is in edge mode. The `release` transition returns to `LN_IDLE` on a clear with no competing edge in the same cycle. The `discard` transition also returns to `LN_IDLE` whenever the line is in level mode.

Top module: `irq_sense_conv`

## Requirements
- R1: After reset, the mask register reads all ones, the polarity and edge-select registers read zero, no latch is held, and `irq_o` is all zero.
- R2: On every cycle, `irq_o[i]` equals raw status bit i AND NOT mask bit i. A mask bit of 1 blocks the line and a mask bit of 0 passes it.
- R3: In level mode (edge-select bit 0), raw status bit i equals the pin when polarity bit i is 1, and equals the inverted pin when polarity bit i is 0. A pin change becomes visible two clock edges after it is applied.
- R4: In edge mode (edge-select bit 1), a rising pin transition (polarity 1) or a falling pin transition (polarity 0) sets the line's latch three clock edges after the pin changes. A transition in the other direction does not set the latch.
- R5: Writing the request-clear register releases each held line whose write-data bit is 1. Bits written as 0 leave their lines unchanged. An all-ones write clears every line. Reads of the request-clear register return 0.
- R6: An edge event on a masked line is still latched. It shows in raw status and drives `irq_o` once the mask bit is written to 0.
- R7: When a clear of a line is sampled on the same clock edge as a new edge event on that line, the line stays held.
- R8: A line in level mode holds no latched state. Switching a line from edge to level mode and back leaves it with nothing pending.
- R9: The register offsets are 0x00 mask, 0x04 request-clear, 0x08 polarity, 0x0C raw status (read-only), and 0x10 edge-select. Reads of any other offset return 0, and writes to other offsets or to raw status change no register.
- R10: A held edge request stays asserted as an active-high level, whatever the pin does afterwards, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | N_LINES | External interrupt pins, asynchronous |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | N_LINES | Write data |
| reg_rdata_o | output | N_LINES | Read data, valid in the cycle of a read strobe, else 0 |
| irq_o | output | N_LINES | Active-high level requests toward the parent controller |

## Verification
The bench times a clear so that it lands on exactly the same edge as a new falling event. A design in which the clear wins would drop that request. It latches edges on masked lines and then unmasks them; a design that gates the latch with the mask would lose those events. It moves latched lines into level mode and back, which exposes a stale latch that comes back as a phantom request. It also drives transitions in the direction opposite to the programmed sense, and writes to unmapped offsets and to the read-only status register, to catch wrong edge decoding and address decoding that is too loose.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    // register byte offsets
    localparam int OFS_MASK  = 'h00;
    localparam int OFS_CLR   = 'h04;
    localparam int OFS_POL   = 'h08;
    localparam int OFS_RAW   = 'h0C;
    localparam int OFS_EDGE  = 'h10;

    // per-line latch state
    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_HELD = 1'b1
    } line_state_e;

endpackage

// File: rtl/irq_sense_sync.sv
module irq_sense_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[LAST];
    end

    assign q_o    = chain[LAST];
    assign prev_o = prev_q;

endmodule

// File: rtl/irq_sense_line.sv
module irq_sense_line
    import irq_sense_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic prev_i,
    input  logic pol_i,
    input  logic edge_i,
    input  logic clr_i,
    output logic raw_o
);
    line_state_e st_q, st_nx;
    logic        ev;

    // edge event from the raw synchronized pair, so a polarity change alone is no event
    assign ev = pol_i ? (lvl_i & ~prev_i) : (~lvl_i & prev_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LN_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            LN_IDLE: if (edge_i && ev) st_nx = LN_HELD;                 // arm
            LN_HELD: begin
                if (!edge_i)            st_nx = LN_IDLE;                 // discard
                else if (clr_i && !ev)  st_nx = LN_IDLE;                 // release
            end
        endcase
    end

    always_comb begin
        if (edge_i) raw_o = (st_q == LN_HELD);
        else        raw_o = pol_i ? lvl_i : ~lvl_i;
    end

    // R7
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && ev) |=> (st_q == LN_HELD));

    // R5
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && st_q == LN_HELD && clr_i && !ev) |=> (st_q == LN_IDLE));

    // R8
    level_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i |=> (st_q == LN_IDLE));

    // R4
    arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == LN_HELD) |-> $past(ev && edge_i));

endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
    import irq_sense_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    input  logic [N-1:0]      raw_i,
    output logic [N-1:0]      reg_rdata,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      edge_o,
    output logic [N-1:0]      clr_o
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);

    logic         wr;
    logic [N-1:0] mask_q, pol_q, edge_q;

    assign wr = reg_valid && reg_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            pol_q  <= '0;
            edge_q <= '0;
        end else if (wr) begin
            if (reg_addr == A_MASK) mask_q <= reg_wdata;
            if (reg_addr == A_POL)  pol_q  <= reg_wdata;
            if (reg_addr == A_EDGE) edge_q <= reg_wdata;
        end
    end

    assign clr_o  = (wr && reg_addr == A_CLR) ? reg_wdata : '0;
    assign mask_o = mask_q;
    assign pol_o  = pol_q;
    assign edge_o = edge_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_write) begin
            case (reg_addr)
                A_MASK:  reg_rdata = mask_q;
                A_POL:   reg_rdata = pol_q;
                A_RAW:   reg_rdata = raw_i;
                A_EDGE:  reg_rdata = edge_q;
                default: reg_rdata = '0;
            endcase
        end
    end

    // R9
    raw_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_addr == A_RAW) |=> ($stable(mask_q) && $stable(pol_q) && $stable(edge_q)));

    // R5
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && reg_addr == A_CLR) |-> (reg_rdata == '0));

endmodule

// File: rtl/irq_sense_conv.sv
module irq_sense_conv
    import irq_sense_pkg::*;
#(
    parameter int N_LINES     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_pin_i,
    input  logic               reg_valid_i,
    input  logic               reg_write_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [N_LINES-1:0] reg_wdata_i,
    output logic [N_LINES-1:0] reg_rdata_o,
    output logic [N_LINES-1:0] irq_o
);
    logic [N_LINES-1:0] lvl, prev, raw, mask, pol, edge_sel, clr;

    irq_sense_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (irq_pin_i),
        .q_o    (lvl),
        .prev_o (prev)
    );

    irq_sense_regs #(.N(N_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid_i),
        .reg_write (reg_write_i),
        .reg_addr  (reg_addr_i),
        .reg_wdata (reg_wdata_i),
        .raw_i     (raw),
        .reg_rdata (reg_rdata_o),
        .mask_o    (mask),
        .pol_o     (pol),
        .edge_o    (edge_sel),
        .clr_o     (clr)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irq_sense_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl[i]),
            .prev_i (prev[i]),
            .pol_i  (pol[i]),
            .edge_i (edge_sel[i]),
            .clr_i  (clr[i]),
            .raw_o  (raw[i])
        );
    end

    assign irq_o = raw & ~mask;

endmodule

// File: tb/irq_sense_conv_bench.sv
module irq_sense_conv_bench;
    localparam int CLK_NS = 10;
    localparam int N  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          valid = 1'b0, write = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata, irq;
    logic          done = 1'b0;
    int            total = 0, bad = 0;

    // behavioural reference state
    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [N-1:0] m_mask = '1, m_pol = '0, m_edge = '0, m_held = '0;

    always #(CLK_NS/2) clk = ~clk;

    irq_sense_conv #(.N_LINES(N), .SYNC_STAGES(2), .ADDR_W(AW)) u_irq_sense_conv (
        .clk(clk), .rst_n(rst_n), .irq_pin_i(pins),
        .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [N-1:0] m_raw();
        return (m_edge & m_held) | (~m_edge & ~(m_s2 ^ m_pol));
    endfunction

    always @(posedge clk) begin : model
        logic [N-1:0] ev, clr, nh;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_mask = '1; m_pol = '0; m_edge = '0; m_held = '0;
        end else begin
            ev  = (m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev);
            clr = (valid && write && addr == 5'h04) ? wdata : '0;
            nh  = m_edge & (ev | (m_held & ~clr));
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
            if (valid && write) begin
                if (addr == 5'h00) m_mask = wdata;
                if (addr == 5'h08) m_pol  = wdata;
                if (addr == 5'h10) m_edge = wdata;
            end
            m_held = nh;
        end
    end

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // R2: per-cycle comparison of the request outputs
    always @(negedge clk) begin
        if (rst_n && !done) check("R2 irq per-cycle", irq, m_raw() & ~m_mask);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
        @(negedge clk);
        valid = 1'b1; write = 1'b0; addr = a;
        #1;
        check(tag, rdata, exp);
        valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 irq after reset", irq, '0);
        rd(5'h00, 32'hFFFF_FFFF, "R1 mask reset");
        rd(5'h08, 32'h0, "R1 polarity reset");
        rd(5'h10, 32'h0, "R1 edge reset");
        rd(5'h0C, 32'hFFFF_FFFF, "R1 raw reset (level-low, pins low)");

        // R9 register map
        wr(5'h08, 32'hFFFF_0000);
        wr(5'h10, 32'h0000_FFFF);
        rd(5'h08, 32'hFFFF_0000, "R9 polarity readback");
        rd(5'h10, 32'h0000_FFFF, "R9 edge readback");
        rd(5'h04, 32'h0, "R5 clear reads zero");
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, 32'h0, "R9 unmapped read");
        wr(5'h0C, 32'h0);
        rd(5'h00, 32'hFFFF_FFFF, "R9 mask untouched");
        rd(5'h08, 32'hFFFF_0000, "R9 polarity untouched");
        rd(5'h10, 32'h0000_FFFF, "R9 edge untouched");

        // R2 unmask
        wr(5'h00, 32'h0);
        idle(3);
        check("R2 unmasked idle", irq, 32'h0);

        // R3 level-high lines
        pins[31:16] = 16'hA5A5;
        idle(3);
        rd(5'h0C, 32'hA5A5_0000, "R3 level high raw");
        check("R3 level irq", irq, 32'hA5A5_0000);

        // R4 falling-edge lines ignore a rise, latch a fall
        pins[3:0] = 4'hF;
        idle(4);
        rd(5'h0C, 32'hA5A5_0000, "R4 opposite edge ignored");
        pins[3:0] = 4'h0;
        idle(4);
        rd(5'h0C, 32'hA5A5_000F, "R4 falling latched");
        idle(5);
        check("R10 held level", irq, 32'hA5A5_000F);

        // R5 partial clear
        wr(5'h04, 32'h0000_0005);
        rd(5'h0C, 32'hA5A5_000A, "R5 clear only ones");

        // R6 masked edges latch
        wr(5'h00, 32'h0000_00F0);
        pins[7:4] = 4'hF;
        idle(3);
        pins[7:4] = 4'h0;
        idle(4);
        rd(5'h0C, 32'hA5A5_00FA, "R6 masked raw");
        check("R6 masked irq", irq, 32'hA5A5_000A);
        wr(5'h00, 32'h0);
        check("R6 unmasked irq", irq, 32'hA5A5_00FA);

        // R7 clear on the same edge as a new event
        pins[8] = 1'b1;
        idle(4);
        @(negedge clk);
        pins[8] = 1'b0;
        @(negedge clk);
        wr(5'h04, 32'h0000_0100);
        idle(2);
        rd(5'h0C, 32'hA5A5_01FA, "R7 edge beats clear");

        // R8 level mode drops latches
        wr(5'h10, 32'h0);
        idle(2);
        rd(5'h0C, 32'hA5A5_FFFF, "R8 level-low view");
        wr(5'h10, 32'h0000_FFFF);
        idle(2);
        rd(5'h0C, 32'hA5A5_0000, "R8 nothing pending after return");

        // R4 rising edges on upper lines
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        idle(2);
        rd(5'h0C, 32'h0, "R8 fresh edge mode empty");
        pins[31:16] = 16'h5A5A;
        idle(4);
        rd(5'h0C, 32'h5A5A_0000, "R4 rising latched");
        rd(5'h0C, m_raw(), "R4 model agreement");

        // R5 clear all, mask all
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h0C, 32'h0, "R5 clear all");
        wr(5'h00, 32'hFFFF_FFFF);
        check("R2 masked all", irq, 32'h0);

        idle(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule